// File: doc/BRIEF.md
# Bulk Bitwise Row-Operation Sequencer

This controller turns one bulk AND or OR request into an ordered series of row-level commands for a memory array. The request names two source rows and one destination row. The controller copies each source into a set-aside working row. It copies a constant row, either all zeros or all ones, into a third working row. It then activates all three working rows at once. In each bit position the array settles to the majority of the three values. With a zero constant that majority is A AND B, and with a ones constant it is A OR B. A last copy moves the result into the destination row, so the operands never leave the memory.

Requests arrive with a valid/ready pair. `req_ready` is high only while the sequencer is idle, and a request is taken on the edge where `req_valid` and `req_ready` are both high. Commands leave through a valid/ready pair. Once `cmd_valid` is raised, the command kind and all three row fields stay frozen until the edge on which `cmd_ready` is high. The downstream port may hold `cmd_ready` low for as long as it needs. After each accepted command the sequencer waits a programmable number of idle cycles before it raises the next one.

Top module: `bbw_seq`

## Requirements
- R1: An accepted valid request produces exactly five commands, in this order: copy A to working row W1; copy B to W2; copy the constant row to W3; triple activation of W1, W2 and W3; copy W1 to the destination. Kind code 1 is a copy, with `cmd_row0` as source and `cmd_row1` as destination. Kind code 2 is a triple activation, with the three rows in `cmd_row0`, `cmd_row1` and `cmd_row2`.
- R2: Opcode 2'b01 is AND and selects the all-zeros constant row. Opcode 2'b10 is OR and selects the all-ones constant row.
- R3: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and the kind and row fields hold their values.
- R4: After a command is accepted, `cmd_valid` stays low for exactly `gap_cycles` cycles before the next command. The gap value is captured when the request is accepted.
- R5: `req_ready` is low from the acceptance of a request until its final copy is accepted. A request presented during that time is not taken, and it changes neither the running sequence nor `err`.
- R6: `done` is high for exactly one cycle, the cycle after the final copy is accepted. `req_ready` is high in that same cycle, so a waiting request is taken on the next edge.
- R7: A request with opcode 2'b00 or 2'b11 is consumed and raises `err` for one cycle, in the cycle after acceptance. It issues no command and leaves `req_ready` high.
- R8: When a row model applies the commands, with triple activation writing the bitwise majority into all three rows, the destination ends up holding A&B for AND and A|B for OR. This also holds when the destination equals a source or the two sources are the same row.
- R9: After reset, `cmd_valid`, `done` and `err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle; request taken when both are high |
| req_op | input | 2 | 01 AND, 10 OR, others rejected |
| req_src_a | input | ROW_W | First source row |
| req_src_b | input | ROW_W | Second source row |
| req_dst | input | ROW_W | Destination row |
| gap_cycles | input | WAIT_W | Idle cycles inserted after each accepted command |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_kind | output | 2 | 1 copy, 2 triple activation |
| cmd_row0 | output | ROW_W | Copy source / first activated row |
| cmd_row1 | output | ROW_W | Copy destination / second activated row |
| cmd_row2 | output | ROW_W | Third activated row (zero for copies) |
| done | output | 1 | One-cycle pulse after the final copy is accepted |
| err | output | 1 | One-cycle pulse for a rejected opcode |

## Verification
Two things can fall in the same cycle: the completion pulse of one sequence and the acceptance of the next request. The bench holds a second request on the port throughout a running sequence. It checks that `req_ready` stays low and the command stream is undisturbed. It then checks that in the cycle where `done` is high, `req_ready` is also high, and that the held request is taken at once and runs its own full five-command sequence.

// File: rtl/bbw_pkg.sv
package bbw_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_COPY   = 2'd1,
    CMD_TRIPLE = 2'd2
  } cmd_kind_e;

  localparam logic [1:0] OPC_AND = 2'b01;
  localparam logic [1:0] OPC_OR  = 2'b10;

  localparam int unsigned NUM_STEPS = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  function automatic logic opc_known(input logic [1:0] op);
    return (op == OPC_AND) || (op == OPC_OR);
  endfunction
endpackage

// File: rtl/bbw_step_map.sv
module bbw_step_map
  import bbw_pkg::*;
#(
  parameter int unsigned ROW_W    = 10,
  parameter int unsigned STEP_W   = 3,
  parameter logic [ROW_W-1:0] W1_ROW   = '0,
  parameter logic [ROW_W-1:0] W2_ROW   = '0,
  parameter logic [ROW_W-1:0] W3_ROW   = '0,
  parameter logic [ROW_W-1:0] ZERO_ROW = '0,
  parameter logic [ROW_W-1:0] ONE_ROW  = '0
) (
  input  logic [STEP_W-1:0] step,
  input  logic              is_and,
  input  logic [ROW_W-1:0]  src_a,
  input  logic [ROW_W-1:0]  src_b,
  input  logic [ROW_W-1:0]  dst,
  output logic [1:0]        kind,
  output logic [ROW_W-1:0]  row0,
  output logic [ROW_W-1:0]  row1,
  output logic [ROW_W-1:0]  row2
);
  logic [ROW_W-1:0] const_row;
  assign const_row = is_and ? ZERO_ROW : ONE_ROW;

  always_comb begin
    kind = CMD_COPY;
    row2 = '0;
    unique case (step)
      3'd0:    begin row0 = src_a;     row1 = W1_ROW; end
      3'd1:    begin row0 = src_b;     row1 = W2_ROW; end
      3'd2:    begin row0 = const_row; row1 = W3_ROW; end
      3'd3:    begin kind = CMD_TRIPLE; row0 = W1_ROW; row1 = W2_ROW; row2 = W3_ROW; end
      default: begin row0 = W1_ROW;    row1 = dst; end
    endcase
  end
endmodule

// File: rtl/bbw_gap_timer.sv
module bbw_gap_timer #(
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bbw_seq.sv
module bbw_seq
  import bbw_pkg::*;
#(
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned WAIT_W = 8,
  parameter logic [ROW_W-1:0] W1_ROW   = ROW_W'((1 << ROW_W) - 5),
  parameter logic [ROW_W-1:0] W2_ROW   = ROW_W'((1 << ROW_W) - 4),
  parameter logic [ROW_W-1:0] W3_ROW   = ROW_W'((1 << ROW_W) - 3),
  parameter logic [ROW_W-1:0] ZERO_ROW = ROW_W'((1 << ROW_W) - 2),
  parameter logic [ROW_W-1:0] ONE_ROW  = ROW_W'((1 << ROW_W) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ROW_W-1:0]  req_src_a,
  input  logic [ROW_W-1:0]  req_src_b,
  input  logic [ROW_W-1:0]  req_dst,
  input  logic [WAIT_W-1:0] gap_cycles,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [ROW_W-1:0]  cmd_row0,
  output logic [ROW_W-1:0]  cmd_row1,
  output logic [ROW_W-1:0]  cmd_row2,
  output logic              done,
  output logic              err
);
  localparam int unsigned STEP_W = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              is_and_q;
  logic [ROW_W-1:0]  a_q, b_q, c_q;
  logic [WAIT_W-1:0] gap_q;
  logic              req_fire, cmd_fire, last_fire, timer_load, timer_exp;

  assign req_ready  = (state_q == ST_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign cmd_valid  = (state_q == ST_ISSUE);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign last_fire  = cmd_fire && (step_q == LAST_STEP);
  assign timer_load = cmd_fire && !last_fire && (gap_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      is_and_q <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      c_q      <= '0;
      gap_q    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= last_fire;
      err  <= req_fire && !opc_known(req_op);
      unique case (state_q)
        ST_IDLE: if (req_fire && opc_known(req_op)) begin
          state_q  <= ST_ISSUE;
          step_q   <= '0;
          is_and_q <= (req_op == OPC_AND);
          a_q      <= req_src_a;
          b_q      <= req_src_b;
          c_q      <= req_dst;
          gap_q    <= gap_cycles;
        end
        ST_ISSUE: if (cmd_fire) begin
          if (last_fire) begin
            state_q <= ST_IDLE;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= (gap_q == '0) ? ST_ISSUE : ST_WAIT;
          end
        end
        ST_WAIT: if (timer_exp) state_q <= ST_ISSUE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  bbw_gap_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (gap_q - 1'b1),
    .expired  (timer_exp)
  );

  bbw_step_map #(
    .ROW_W(ROW_W), .STEP_W(STEP_W),
    .W1_ROW(W1_ROW), .W2_ROW(W2_ROW), .W3_ROW(W3_ROW),
    .ZERO_ROW(ZERO_ROW), .ONE_ROW(ONE_ROW)
  ) u_map (
    .step   (step_q),
    .is_and (is_and_q),
    .src_a  (a_q),
    .src_b  (b_q),
    .dst    (c_q),
    .kind   (cmd_kind),
    .row0   (cmd_row0),
    .row1   (cmd_row1),
    .row2   (cmd_row2)
  );
endmodule

// File: rtl/bbw_seq_chk.sv
module bbw_seq_chk
  import bbw_pkg::*;
#(
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned WAIT_W = 8,
  parameter logic [ROW_W-1:0] W1_ROW = '0,
  parameter logic [ROW_W-1:0] W2_ROW = '0,
  parameter logic [ROW_W-1:0] W3_ROW = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_kind,
  input logic [ROW_W-1:0] cmd_row0,
  input logic [ROW_W-1:0] cmd_row1,
  input logic [ROW_W-1:0] cmd_row2,
  input logic             done,
  input logic             err
);
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) &&
      $stable(cmd_row0) && $stable(cmd_row1) && $stable(cmd_row2));

  a_r5_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_valid && cmd_ready && cmd_kind == CMD_COPY) && req_ready);

  a_r7_err_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !cmd_valid && req_ready);

  a_r1_triple_rows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == CMD_TRIPLE |->
      cmd_row0 == W1_ROW && cmd_row1 == W2_ROW && cmd_row2 == W3_ROW);
endmodule

bind bbw_seq bbw_seq_chk #(
  .ROW_W(ROW_W), .WAIT_W(WAIT_W),
  .W1_ROW(W1_ROW), .W2_ROW(W2_ROW), .W3_ROW(W3_ROW)
) u_chk (.*);

// File: tb/bbw_seq_tb.sv
module bbw_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 4;
  localparam int WW = 4;
  localparam int DW = 16;
  localparam logic [RW-1:0] W1 = 4'd11, W2 = 4'd12, W3 = 4'd13, RZ = 4'd14, RO = 4'd15;
  localparam int NV = 6;
  localparam logic [1:0]    T_OP   [NV] = '{2'b01, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10};
  localparam logic [RW-1:0] T_A    [NV] = '{4'd1, 4'd4, 4'd7, 4'd1, 4'd5, 4'd0};
  localparam logic [RW-1:0] T_B    [NV] = '{4'd2, 4'd5, 4'd8, 4'd2, 4'd5, 4'd10};
  localparam logic [RW-1:0] T_C    [NV] = '{4'd3, 4'd6, 4'd9, 4'd1, 4'd10, 4'd0};
  localparam logic [WW-1:0] T_GAP  [NV] = '{4'd0, 4'd2, 4'd3, 4'd1, 4'd0, 4'd15};
  localparam int            T_STL  [NV] = '{0, 1, 2, 0, 3, 0};
  localparam logic [DW-1:0] T_DA   [NV] = '{16'hF0F0, 16'h1234, 16'hAAAA, 16'h0F0F, 16'hBEEF, 16'h0000};
  localparam logic [DW-1:0] T_DB   [NV] = '{16'hFF00, 16'h8421, 16'h5555, 16'h3C3C, 16'hBEEF, 16'h0000};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, cmd_ready = 1'b0;
  logic [1:0] req_op = '0;
  logic [RW-1:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
  logic [WW-1:0] gap_cycles = '0;
  logic req_ready, cmd_valid, done, err;
  logic [1:0] cmd_kind;
  logic [RW-1:0] cmd_row0, cmd_row1, cmd_row2;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  bbw_seq #(.ROW_W(RW), .WAIT_W(WW), .W1_ROW(W1), .W2_ROW(W2), .W3_ROW(W3),
            .ZERO_ROW(RZ), .ONE_ROW(RO)) u_dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one sequence; pend=1 keeps another request on the port while busy.
  task automatic run_seq(input logic [1:0] op, input logic [RW-1:0] a, b, c,
                         input logic [WW-1:0] gap, input int stall,
                         input bit prereq, input bit pend,
                         input logic [1:0] p_op, input logic [RW-1:0] pa, pb, pc);
    int idx = 0, low = 0, stl = stall, guard = 0;
    logic [1:0] pk; logic [RW-1:0] p0, p1, p2;
    logic held = 1'b0;
    logic [RW-1:0] kr;
    logic [DW-1:0] m;
    kr = (op == 2'b01) ? RZ : RO;
    if (!prereq) begin
      @(negedge clk);
      chk("R5 ready idle", req_ready, 1);
      req_valid = 1'b1; req_op = op; req_src_a = a; req_src_b = b; req_dst = c; gap_cycles = gap;
    end
    @(negedge clk);
    if (pend) begin
      req_op = p_op; req_src_a = pa; req_src_b = pb; req_dst = pc; gap_cycles = '0;
    end else req_valid = 1'b0;
    while (idx < 5 && guard < 400) begin
      guard++;
      if (req_ready !== 1'b0) chk("R5 busy ready low", req_ready, 0);
      if (err !== 1'b0) chk("R5 no err while busy", err, 0);
      if (cmd_valid) begin
        if (held) begin
          chk("R3 hold", {cmd_kind, cmd_row0, cmd_row1, cmd_row2}, {pk, p0, p1, p2});
        end
        if (stl > 0) begin
          stl--; cmd_ready = 1'b0; held = 1'b1;
          pk = cmd_kind; p0 = cmd_row0; p1 = cmd_row1; p2 = cmd_row2;
        end else begin
          held = 1'b0; cmd_ready = 1'b1; stl = stall;
          if (idx > 0) chk("R4 gap", low, gap);
          case (idx)
            0: chk("R1 step0", {cmd_kind, cmd_row0, cmd_row1}, {2'd1, a, W1});
            1: chk("R1 step1", {cmd_kind, cmd_row0, cmd_row1}, {2'd1, b, W2});
            2: chk("R2 const", {cmd_kind, cmd_row0, cmd_row1}, {2'd1, kr, W3});
            3: chk("R1 triple", {cmd_kind, cmd_row0, cmd_row1, cmd_row2}, {2'd2, W1, W2, W3});
            default: chk("R1 final", {cmd_kind, cmd_row0, cmd_row1}, {2'd1, W1, c});
          endcase
          if (cmd_kind == 2'd2) begin
            m = (mem[cmd_row0] & mem[cmd_row1]) | (mem[cmd_row1] & mem[cmd_row2]) |
                (mem[cmd_row0] & mem[cmd_row2]);
            mem[cmd_row0] = m; mem[cmd_row1] = m; mem[cmd_row2] = m;
          end else mem[cmd_row1] = mem[cmd_row0];
          idx++; low = 0;
        end
      end else begin
        cmd_ready = 1'b0;
        low++;
      end
      if (idx < 5) @(negedge clk);
    end
    @(negedge clk);
    cmd_ready = 1'b0;
    chk("R6 done pulse", {done, req_ready}, 2'b11);
    if (!pend) begin
      @(negedge clk);
      chk("R6 done single", done, 0);
    end
  endtask

  task automatic preload(input int i);
    for (int r = 0; r < 16; r++) mem[r] = DW'(16'hD000 + r);
    mem[RZ] = '0; mem[RO] = '1;
    mem[T_A[i]] = T_DA[i];
    mem[T_B[i]] = T_DB[i];
  endtask

  initial begin
    logic [DW-1:0] exp;
    // R9 reset state
    #(CLK_PERIOD*2 + 2);
    chk("R9 reset", {cmd_valid, done, err, req_ready}, 4'b0001);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release", {cmd_valid, done, err, req_ready}, 4'b0001);

    // Table walk: R1 R2 R3 R4 R8
    for (int i = 0; i < NV; i++) begin
      preload(i);
      exp = (T_OP[i] == 2'b01) ? (T_DA[i] & T_DB[i]) : (T_DA[i] | T_DB[i]);
      run_seq(T_OP[i], T_A[i], T_B[i], T_C[i], T_GAP[i], T_STL[i], 0, 0, 2'b00, '0, '0, '0);
      chk("R8 result", mem[T_C[i]], exp);
    end

    // R7 unknown opcodes
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_op = (k == 0) ? 2'b00 : 2'b11;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7 err pulse", {err, cmd_valid, req_ready}, 3'b101);
      @(negedge clk);
      chk("R7 err clears no cmd", {err, cmd_valid, req_ready}, 3'b001);
      @(negedge clk);
      chk("R7 still no cmd", cmd_valid, 0);
    end

    // R5/R6 pending request accepted in the done cycle, then runs itself
    preload(0);
    mem[4] = 16'h00FF; mem[5] = 16'h0F0F;
    run_seq(2'b01, 4'd1, 4'd2, 4'd3, 4'd1, 1, 0, 1, 2'b10, 4'd4, 4'd5, 4'd6);
    chk("R8 first of pair", mem[3], 16'hF0F0 & 16'hFF00);
    run_seq(2'b10, 4'd4, 4'd5, 4'd6, 4'd0, 0, 1, 0, 2'b00, '0, '0, '0);
    chk("R5 pending op result R8", mem[6], 16'h0FFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule